// File: doc/BRIEF.md
# Cartridge Disk Controller Register Block

This block is the software-visible register front end of a controller that serves up to four cartridge disk drives. A bus master reaches five 16-bit registers through a single-cycle word or byte access port: a control/status register, a bus address register, a disk address register, a multipurpose register, and a bus address extension register. The block keeps the error summary, shares the low two bits of the extension between two registers, owns the done flag and the interrupt request, and holds a small queue behind the multipurpose register. A queue read returns the oldest word and moves the others forward.

A small state machine tracks whether the controller is idle or has work in flight. It has two states. DONE_IDLE is the reset state, and the done bit reads 1. RUNNING means a command has been handed off, and the done bit reads 0. It has three named transitions. ISSUE is a control/status write with the done bit clear. It moves to RUNNING and sends a one-cycle start strobe to an external sequencer. FORCE_DONE is a control/status write with the done bit set. It moves to DONE_IDLE and starts nothing. FINISH is the sequencer's completion pulse. It moves to DONE_IDLE, merges the reported error bits, and can load the queue with status words. The sequencer also reports which drives are busy. That input feeds the drive-ready bit.

Top module: `dkc_regfile`

## Requirements
- R1: After reset, the control/status register reads 0x0080 plus the ready bit. The bus address, disk address, multipurpose and extension registers read 0. `irq` is low.
- R2: Byte address bits 3:1 select the register: 0 control/status, 1 bus address, 2 disk address, 3 multipurpose, 4 extension. Selects 5 to 7 read as zero, ignore writes, and raise no error.
- R3: The control/status fields are as follows. Bit 0 is ready, which reads 1 only when the drive named in bits 9:8 is not busy. Bits 3:1 are the function, bits 5:4 the extension mirror, bit 6 interrupt enable, bit 7 done and bits 9:8 the drive.
- R4: Control/status bits 14:10 hold error flags. Bit 15 reads 1 exactly when any of bits 14:10 is 1.
- R5: Software writes change only control/status bits 9:1. Written values in bits 15:10 and bit 0 have no effect.
- R6: A control/status write with bit 7 set starts no command and leaves the errors alone. If bit 6 is clear, `irq` drops. If bit 6 is set, `irq` rises only if done was already 1 before the write. Otherwise `irq` holds.
- R7: A control/status write with bit 7 clear does four things. It clears `irq` and all error flags. It makes done read 0. In the next cycle it pulses `cmd_start` for one cycle, with `cmd_func` and `cmd_drive` equal to the written bits 3:1 and 9:8.
- R8: A `cmp_valid` pulse sets done and ORs `cmp_errs` (bits 4:0 map to control/status bits 14:10) into the error flags. It sets `irq` equal to interrupt enable. A control/status write in the same cycle takes precedence, and the completion is dropped.
- R9: A multipurpose write loads the merged value into all three queue entries. Completion with `cmp_mp_load` loads entry i from `cmp_mp_words[16i+15:16i]`. A read returns entry 0 and shifts the queue down by one, with the last entry keeping its value.
- R10: Bit 0 of the bus address register always reads 0.
- R11: The extension register holds 6 bits. Its bits 1:0 and control/status bits 5:4 are a single value: a write through either register is visible in both. An odd-address byte write to the extension register has no effect.
- R12: For byte accesses, the data comes on `bus_wdata[7:0]`. When `bus_addr[0]` is 1, the write replaces the high byte. When it is 0, the write replaces the low byte. The other byte is kept.
- R13: With `HAS_EXT` = 0, any access to the extension select raises `bus_err` and reads 0. Writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_byte | input | 1 | 1 = byte access |
| bus_addr | input | 4 | Byte address; bits 3:1 select, bit 0 byte lane |
| bus_wdata | input | 16 | Write data (byte data on bits 7:0) |
| bus_rdata | output | 16 | Read data, valid in the access cycle |
| bus_err | output | 1 | Bus error response for the access |
| drive_busy | input | NUM_DRIVES | Per-drive busy from the sequencer |
| cmp_valid | input | 1 | Command completion pulse |
| cmp_errs | input | 5 | Error flags to merge on completion |
| cmp_mp_load | input | 1 | Load the queue entries on completion |
| cmp_mp_words | input | MP_DEPTH*16 | Status words, entry 0 in the low bits |
| cmd_start | output | 1 | One-cycle command start strobe |
| cmd_func | output | 3 | Function of the issued command |
| cmd_drive | output | 2 | Drive of the issued command |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the default configuration, which has four drives, a three-entry queue and the extension register present. With this configuration it sweeps all eight functions on all four drives, all 32 error-flag combinations, and all 16 busy patterns against each drive select. A second instance is built with `HAS_EXT` = 0. It makes the bus-error response reachable, while the mirrored extension bits still work through the control/status register.

// File: rtl/dkc_pkg.sv
package dkc_pkg;
    localparam int WORD_W = 16;
    localparam logic [2:0] SEL_CS  = 3'd0;
    localparam logic [2:0] SEL_BA  = 3'd1;
    localparam logic [2:0] SEL_DA  = 3'd2;
    localparam logic [2:0] SEL_MP  = 3'd3;
    localparam logic [2:0] SEL_EXT = 3'd4;

    typedef enum logic { ST_DONE_IDLE, ST_RUNNING } ctl_state_e;

    // Byte-lane merge: byte data arrives on bits 7:0
    function automatic logic [WORD_W-1:0] lane_merge(
        input logic [WORD_W-1:0] cur,
        input logic [WORD_W-1:0] wd,
        input logic              byte_acc,
        input logic              odd);
        if (!byte_acc)
            return wd;
        else if (odd)
            return {wd[7:0], cur[7:0]};
        else
            return {cur[15:8], wd[7:0]};
    endfunction
endpackage

// File: rtl/dkc_ctl_fsm.sv
module dkc_ctl_fsm
    import dkc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_wr,
    input  logic wr_done_bit,
    input  logic wr_ie_bit,
    input  logic cur_ie,
    input  logic cmp_valid,
    output logic done,
    output logic irq,
    output logic start
);
    ctl_state_e state_q, state_nx;
    logic       irq_q, irq_nx;
    logic       start_q, start_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_DONE_IDLE;
            irq_q   <= 1'b0;
            start_q <= 1'b0;
        end else begin
            state_q <= state_nx;
            irq_q   <= irq_nx;
            start_q <= start_nx;
        end
    end

    always_comb begin
        state_nx = state_q;
        irq_nx   = irq_q;
        start_nx = 1'b0;
        unique case (state_q)
            ST_DONE_IDLE: begin
                if (cs_wr && wr_done_bit) begin          // FORCE_DONE
                    irq_nx = wr_ie_bit;
                end else if (cs_wr) begin                // ISSUE
                    state_nx = ST_RUNNING;
                    irq_nx   = 1'b0;
                    start_nx = 1'b1;
                end else if (cmp_valid) begin            // FINISH
                    irq_nx = cur_ie;
                end
            end
            ST_RUNNING: begin
                if (cs_wr && wr_done_bit) begin          // FORCE_DONE
                    state_nx = ST_DONE_IDLE;
                    if (!wr_ie_bit) irq_nx = 1'b0;
                end else if (cs_wr) begin                // ISSUE
                    irq_nx   = 1'b0;
                    start_nx = 1'b1;
                end else if (cmp_valid) begin            // FINISH
                    state_nx = ST_DONE_IDLE;
                    irq_nx   = cur_ie;
                end
            end
            default: state_nx = ST_DONE_IDLE;
        endcase
    end

    assign done  = (state_q == ST_DONE_IDLE);
    assign irq   = irq_q;
    assign start = start_q;

    assert_start_running_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |-> state_q == ST_RUNNING);
    assert_irq_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> (cur_ie && state_q == ST_DONE_IDLE));
    assert_finish_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && !cs_wr) |=> state_q == ST_DONE_IDLE);
endmodule

// File: rtl/dkc_mp_queue.sv
module dkc_mp_queue #(
    parameter int DEPTH = 3,
    parameter int W     = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_all,
    input  logic [W-1:0]   all_val,
    input  logic           load_each,
    input  logic [DEPTH*W-1:0] each_val,
    input  logic           pop,
    output logic [W-1:0]   head
);
    logic [W-1:0] q [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[gi] <= '0;
            else if (load_each)
                q[gi] <= each_val[gi*W +: W];
            else if (load_all)
                q[gi] <= all_val;
            else if (pop && gi < DEPTH-1)
                q[gi] <= q[(gi < DEPTH-1) ? gi+1 : gi];
        end
    end

    assign head = q[0];

    if (DEPTH > 1) begin : g_chk
        assert_mp_shift_R9: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(pop) && !$past(load_all) && !$past(load_each)) |-> q[0] == $past(q[1]));
    end
endmodule

// File: rtl/dkc_regfile.sv
module dkc_regfile
    import dkc_pkg::*;
#(
    parameter int NUM_DRIVES = 4,
    parameter int MP_DEPTH   = 3,
    parameter int EXT_W      = 6,
    parameter bit HAS_EXT    = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_req,
    input  logic                     bus_wr,
    input  logic                     bus_byte,
    input  logic [3:0]               bus_addr,
    input  logic [15:0]              bus_wdata,
    output logic [15:0]              bus_rdata,
    output logic                     bus_err,
    input  logic [NUM_DRIVES-1:0]    drive_busy,
    input  logic                     cmp_valid,
    input  logic [4:0]               cmp_errs,
    input  logic                     cmp_mp_load,
    input  logic [MP_DEPTH*16-1:0]   cmp_mp_words,
    output logic                     cmd_start,
    output logic [2:0]               cmd_func,
    output logic [1:0]               cmd_drive,
    output logic                     irq
);
    localparam int SEL_SLOTS = 4;   // drive select field is 2 bits

    logic [2:0]       sel;
    logic             rd_acc, wr_acc, odd;
    logic [2:0]       func_q;
    logic [1:0]       drv_q;
    logic             ie_q;
    logic [4:0]       err_q;
    logic [EXT_W-1:0] ext_q;
    logic [15:0]      ba_q, da_q, mp_head;
    logic [15:0]      cs_cur, merged;
    logic [SEL_SLOTS-1:0] busy4;
    logic             done, ready;
    logic             cs_wr, mp_pop, mp_wr;

    assign sel    = bus_addr[3:1];
    assign odd    = bus_addr[0];
    assign rd_acc = bus_req && !bus_wr;
    assign wr_acc = bus_req && bus_wr;

    for (genvar gi = 0; gi < SEL_SLOTS; gi++) begin : g_busy
        if (gi < NUM_DRIVES) begin : g_real
            assign busy4[gi] = drive_busy[gi];
        end else begin : g_absent
            assign busy4[gi] = 1'b1;
        end
    end

    assign ready  = !busy4[drv_q];
    assign cs_cur = {|err_q, err_q, drv_q, done, ie_q, ext_q[1:0], func_q, ready};

    always_comb begin
        case (sel)
            SEL_CS:  merged = lane_merge(cs_cur, bus_wdata, bus_byte, odd);
            SEL_BA:  merged = lane_merge(ba_q, bus_wdata, bus_byte, odd);
            SEL_DA:  merged = lane_merge(da_q, bus_wdata, bus_byte, odd);
            SEL_MP:  merged = lane_merge(mp_head, bus_wdata, bus_byte, odd);
            default: merged = bus_wdata;
        endcase
    end

    assign cs_wr  = wr_acc && sel == SEL_CS;
    assign mp_wr  = wr_acc && sel == SEL_MP;
    assign mp_pop = rd_acc && sel == SEL_MP;

    dkc_ctl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_wr      (cs_wr),
        .wr_done_bit(merged[7]),
        .wr_ie_bit  (merged[6]),
        .cur_ie     (ie_q),
        .cmp_valid  (cmp_valid),
        .done       (done),
        .irq        (irq),
        .start      (cmd_start)
    );

    dkc_mp_queue #(.DEPTH(MP_DEPTH), .W(16)) u_mpq (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_all (mp_wr),
        .all_val  (merged),
        .load_each(cmp_valid && cmp_mp_load && !cs_wr),
        .each_val (cmp_mp_words),
        .pop      (mp_pop),
        .head     (mp_head)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            func_q <= '0;
            drv_q  <= '0;
            ie_q   <= 1'b0;
            err_q  <= '0;
            ext_q  <= '0;
            ba_q   <= '0;
            da_q   <= '0;
        end else begin
            if (cs_wr) begin
                func_q     <= merged[3:1];
                ext_q[1:0] <= merged[5:4];
                ie_q       <= merged[6];
                drv_q      <= merged[9:8];
                if (!merged[7]) err_q <= '0;
            end else if (cmp_valid) begin
                err_q <= err_q | cmp_errs;
            end
            if (wr_acc && sel == SEL_BA) ba_q <= merged & 16'hFFFE;
            if (wr_acc && sel == SEL_DA) da_q <= merged;
            if (HAS_EXT && wr_acc && sel == SEL_EXT && !(bus_byte && odd))
                ext_q <= bus_wdata[EXT_W-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        bus_err   = 1'b0;
        case (sel)
            SEL_CS:  bus_rdata = cs_cur;
            SEL_BA:  bus_rdata = ba_q;
            SEL_DA:  bus_rdata = da_q;
            SEL_MP:  bus_rdata = mp_head;
            SEL_EXT: begin
                if (HAS_EXT) bus_rdata = 16'(ext_q);
                else         bus_err   = bus_req;
            end
            default: bus_rdata = '0;
        endcase
    end

    assign cmd_func  = func_q;
    assign cmd_drive = drv_q;

    assert_err_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |-> err_q == 5'd0);
    assert_ba_even_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && sel == SEL_BA) |-> !bus_rdata[0]);
endmodule

// File: tb/dkc_regfile_bench.sv
`timescale 1ns/100ps
module dkc_regfile_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 0, bus_wr = 0, bus_byte = 0;
    logic [3:0]  bus_addr = 0;
    logic [15:0] bus_wdata = 0;
    logic [15:0] rdata, rdata_nx;
    logic        berr, berr_nx;
    logic [3:0]  drive_busy = 0;
    logic        cmp_valid = 0, cmp_mp_load = 0;
    logic [4:0]  cmp_errs = 0;
    logic [47:0] cmp_mp_words = 0;
    logic        cmd_start, cmd_start_nx;
    logic [2:0]  cmd_func, cmd_func_nx;
    logic [1:0]  cmd_drive, cmd_drive_nx;
    logic        irq, irq_nx;
    logic [15:0] last_rd;
    logic        last_err, last_err_nx;
    int total = 0, bad = 0;

    always #2 clk = ~clk;

    dkc_regfile u_dkc_regfile (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
        .bus_byte(bus_byte), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(rdata), .bus_err(berr), .drive_busy(drive_busy),
        .cmp_valid(cmp_valid), .cmp_errs(cmp_errs), .cmp_mp_load(cmp_mp_load),
        .cmp_mp_words(cmp_mp_words), .cmd_start(cmd_start), .cmd_func(cmd_func),
        .cmd_drive(cmd_drive), .irq(irq));

    dkc_regfile #(.HAS_EXT(1'b0)) u_dkc_regfile_noext (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
        .bus_byte(bus_byte), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(rdata_nx), .bus_err(berr_nx), .drive_busy(drive_busy),
        .cmp_valid(cmp_valid), .cmp_errs(cmp_errs), .cmp_mp_load(cmp_mp_load),
        .cmp_mp_words(cmp_mp_words), .cmd_start(cmd_start_nx), .cmd_func(cmd_func_nx),
        .cmd_drive(cmd_drive_nx), .irq(irq_nx));

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    function automatic logic [15:0] cs_exp(int e, int d, int dn, int ie, int x, int f, int rdy);
        return 16'((e != 0 ? 32'h8000 : 0) | (e << 10) | (d << 8) | (dn << 7)
                   | (ie << 6) | (x << 4) | (f << 1) | rdy);
    endfunction

    // Tasks start and end at posedge + 0.5 ns
    task automatic wr(input logic [3:0] a, input logic [15:0] d, input logic b);
        bus_req = 1; bus_wr = 1; bus_byte = b; bus_addr = a; bus_wdata = d;
        @(posedge clk); #0.5;
        bus_req = 0; bus_wr = 0; bus_byte = 0;
    endtask

    task automatic rd(input logic [3:0] a);
        bus_req = 1; bus_wr = 0; bus_byte = 0; bus_addr = a;
        #1 last_rd = rdata; last_err = berr; last_err_nx = berr_nx;
        @(posedge clk); #0.5;
        bus_req = 0;
    endtask

    task automatic finish_cmd(input logic [4:0] e, input logic ld, input logic [47:0] w);
        cmp_valid = 1; cmp_errs = e; cmp_mp_load = ld; cmp_mp_words = w;
        @(posedge clk); #0.5;
        cmp_valid = 0; cmp_errs = 0; cmp_mp_load = 0;
    endtask

    initial begin
        #400000;
        bad++; total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #0.5 rst_n = 1;
        @(posedge clk); #0.5;

        // R1 reset state
        rd(0); chk("R1 cs", last_rd, 16'h0081);
        rd(2); chk("R1 ba", last_rd, 0);
        rd(4); chk("R1 da", last_rd, 0);
        rd(6); chk("R1 mp", last_rd, 0);
        rd(8); chk("R1 ext", last_rd, 0);
        chk("R1 irq", 16'(irq), 0);

        // R7 R3 function and drive sweep, R8 completion
        for (int f = 0; f < 8; f++) begin
            for (int d = 0; d < 4; d++) begin
                wr(0, 16'((d << 8) | (f << 1)), 0);
                chk("R7 start", 16'(cmd_start), 1);
                chk("R7 func", 16'(cmd_func), 16'(f));
                chk("R7 drive", 16'(cmd_drive), 16'(d));
                rd(0);
                chk("R7 start_once", 16'(cmd_start), 0);
                chk("R3 cs_run", last_rd, cs_exp(0, d, 0, 0, 0, f, 1));
                finish_cmd(0, 0, 0);
                rd(0); chk("R8 cs_done", last_rd, cs_exp(0, d, 1, 0, 0, f, 1));
            end
        end

        // R4 R8 error-flag sweep, R7 error clear
        for (int e = 0; e < 32; e++) begin
            wr(0, 16'h0000, 0);
            rd(0); chk("R7 err_clear", last_rd, cs_exp(0, 0, 0, 0, 0, 0, 1));
            finish_cmd(5'(e), 0, 0);
            rd(0); chk("R4 err_sum", last_rd, cs_exp(e, 0, 1, 0, 0, 0, 1));
        end

        // R5 writable mask, R6 irq raise with done already set, R11 mirror
        wr(0, 16'h0000, 0); finish_cmd(0, 0, 0);
        wr(0, 16'hFCFF, 0);
        chk("R6 no_start", 16'(cmd_start), 0);
        chk("R6 irq_rise", 16'(irq), 1);
        rd(0); chk("R5 mask", last_rd, 16'h00FF);
        rd(8); chk("R11 cs_to_ext", last_rd, 16'h0003);
        wr(0, 16'h0080, 0);
        chk("R6 irq_drop", 16'(irq), 0);
        rd(0); chk("R6 cs", last_rd, 16'h0081);

        // R6 hold, R8 irq follows enable, R7 irq clear
        wr(0, 16'h0000, 0); finish_cmd(5'b00001, 0, 0);
        chk("R8 irq_off", 16'(irq), 0);
        rd(0); chk("R8 err_bit10", last_rd, cs_exp(1, 0, 1, 0, 0, 0, 1));
        wr(0, 16'h0040, 0);
        rd(0); chk("R7 clear_err", last_rd, 16'h0041);
        wr(0, 16'h00C0, 0);
        chk("R6 irq_hold", 16'(irq), 0);
        chk("R6 no_start2", 16'(cmd_start), 0);
        rd(0); chk("R6 cs_forced", last_rd, 16'h00C1);
        wr(0, 16'h0040, 0); finish_cmd(0, 0, 0);
        chk("R8 irq_on", 16'(irq), 1);
        wr(0, 16'h0040, 0);
        chk("R7 irq_clear", 16'(irq), 0);
        finish_cmd(0, 0, 0);
        chk("R8 irq_on2", 16'(irq), 1);
        wr(0, 16'h0080, 0);
        chk("R6 irq_drop2", 16'(irq), 0);

        // R3 ready sweep over busy patterns
        for (int b = 0; b < 16; b++) begin
            drive_busy = 4'(b);
            for (int d = 0; d < 4; d++) begin
                wr(0, 16'((d << 8) | 16'h0080), 0);
                rd(0); chk("R3 ready", 16'(last_rd[0]), 16'(((b >> d) & 1) == 0));
            end
        end
        drive_busy = 0;
        wr(0, 16'h0080, 0);

        // R9 queue
        wr(6, 16'h1111, 0);
        rd(6); chk("R9 load_all0", last_rd, 16'h1111);
        rd(6); chk("R9 load_all1", last_rd, 16'h1111);
        for (int p = 0; p < 4; p++) begin
            logic [15:0] a0, a1, a2;
            a0 = 16'(16'h0A00 + p); a1 = 16'(16'h0B00 + p * 3); a2 = 16'(16'h0C00 + p * 7);
            finish_cmd(0, 1, {a2, a1, a0});
            rd(6); chk("R9 e0", last_rd, a0);
            rd(6); chk("R9 e1", last_rd, a1);
            rd(6); chk("R9 e2", last_rd, a2);
            rd(6); chk("R9 tail", last_rd, a2);
        end

        // R12 byte lanes on disk address, multipurpose and bus address
        wr(4, 16'h1234, 0);
        wr(5, 16'h00AB, 1); rd(4); chk("R12 da_hi", last_rd, 16'hAB34);
        wr(4, 16'h00CD, 1); rd(4); chk("R12 da_lo", last_rd, 16'hABCD);
        wr(6, 16'h1234, 0); wr(7, 16'h0056, 1);
        rd(6); chk("R12 mp_hi", last_rd, 16'h5634);
        rd(6); chk("R12 mp_hi_all", last_rd, 16'h5634);

        // R10 bus address bit 0
        for (int v = 0; v < 8; v++) begin
            logic [15:0] val;
            val = 16'(v * 16'h2493 + 1);
            wr(2, val, 0);
            rd(2); chk("R10 ba", last_rd, val & 16'hFFFE);
        end
        wr(3, 16'h00FF, 1); rd(2); chk("R12 ba_hi", last_rd, 16'hFF00 | ((16'(7 * 16'h2493 + 1)) & 16'h00FE));

        // R11 extension width and mirror, R13 bus error
        wr(8, 16'hFFFF, 0);
        rd(8); chk("R11 ext6", last_rd, 16'h003F);
        chk("R13 main_no_err", 16'(last_err), 0);
        chk("R13 noext_err", 16'(last_err_nx), 1);
        rd(0); chk("R11 ext_to_cs", last_rd, 16'h00B1);
        wr(0, 16'h0090, 0);
        rd(8); chk("R11 cs_to_ext", last_rd, 16'h003D);
        wr(9, 16'h0000, 1);
        rd(8); chk("R11 odd_ignored", last_rd, 16'h003D);
        bus_req = 1; bus_addr = 8; #1;
        chk("R13 noext_rd", rdata_nx, 16'h0000);
        @(posedge clk); #0.5 bus_req = 0;

        // R2 unmapped selects
        for (int s = 5; s < 8; s++) begin
            wr(4'(s * 2), 16'hBEEF, 0);
            rd(4'(s * 2));
            chk("R2 unmapped", last_rd, 0);
            chk("R2 no_err", 16'(last_err), 0);
        end
        rd(4); chk("R2 da_kept", last_rd, 16'hABCD);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule